// File: doc/BRIEF.md
# Sampling Converter Serial Output Port

This block is the digital half of a 16-bit sampling converter. It watches two active-level controls, a chip select and a read/convert line. The relative edges of these two lines either begin a conversion or open a read of the stored result. Analog sampling is outside the block. The sample arrives as a two's complement word on `sample_in` and is captured at the moment a conversion is accepted. A busy flag goes low for a fixed number of system clock cycles. At the end of that time the captured word is stored as the new result, coded either as two's complement or as straight binary.

The result leaves on one serial line, most significant bit first, in one of two ways. In internal-clock mode, every accepted conversion produces a burst of exactly sixteen data clock pulses that carries the result of the conversion before it. In external-clock mode, a read request arms the port. The next rising edge of an external data clock raises a one-period frame sync pulse, and the data bits follow on later edges. A tag input is shifted in behind the data word so that several ports can be chained onto one line.

Top module: `adc_serial_port`

## Requirements
- R1: A conversion is requested by a falling `rd_conv` while `cs_n` is low, or by a falling `cs_n` while `rd_conv` is low. When accepted, the request captures `sample_in`, `fmt_straight` and `tag_in` and drives `busy_n` low.
- R2: `busy_n` stays low for exactly CONV_CYCLES system clock cycles. It returns high in the same cycle that the captured word becomes the stored result.
- R3: A conversion request made while `busy_n` is low is ignored. It does not lengthen the busy time and does not change the stored result.
- R4: While `pwr_down` is high, conversion requests are refused: `busy_n` stays high and the stored result is kept for later reads.
- R5: With `fmt_straight` = 0 the stored result equals the captured sample (two's complement). With `fmt_straight` = 1 the most significant bit is inverted (straight binary).
- R6: In internal mode (`ext_mode` = 0), each accepted conversion emits exactly 16 high pulses on `dclk_o`, each CLK_HALF cycles long. The pulses carry the previous stored result on `dout`, MSB first, and `sync_o` stays low.
- R7: In internal mode, `dout` changes only while `dclk_o` is low, so each bit is valid on both edges of its pulse.
- R8: After an internal burst, `dout` holds the `tag_in` level captured when the conversion was accepted, until the next burst.
- R9: A read is requested by a rising `rd_conv` while `cs_n` is low, or by a falling `cs_n` while `rd_conv` is high. A read has effect only in external mode. In internal mode it leaves `dout` unchanged and emits no `dclk_o` pulse. In external mode `dclk_o` stays low.
- R10: After a read request in external mode, the first rising edge of `ext_dclk` raises `sync_o`, and the second edge lowers it. The second through seventeenth edges put the stored result on `dout`, MSB first.
- R11: In external mode, the `tag_in` level present at one rising data edge appears on `dout` sixteen edges later. That is seventeen edges after the read request counting the sync edge.
- R12: A read made while a conversion is still running returns the result of the previous conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | Read (high) / convert (low) control |
| ext_mode | input | 1 | 1 selects the external data clock, 0 the internal burst |
| fmt_straight | input | 1 | 1 selects straight binary coding, 0 two's complement |
| pwr_down | input | 1 | High blocks new conversions |
| tag_in | input | 1 | Daisy-chain input shifted in behind the data |
| sample_in | input | WORD_W | Sample value in two's complement |
| ext_dclk | input | 1 | External data clock, asynchronous, oversampled |
| busy_n | output | 1 | Low while a conversion runs |
| dout | output | 1 | Serial data |
| dclk_o | output | 1 | Internal data clock burst |
| sync_o | output | 1 | Frame sync in external mode |

## Verification
The sample words include the two extreme codes, zero and all ones, followed by random words, each under a random choice of coding. This separates a correct MSB inversion from a whole-word inversion or an ignored format flag. Conversions are started by both control orderings, and reads by both edge combinations, so that a decoder that recognises only one ordering is exposed. Random tag patterns shifted through external frames tell a sixteen-edge delay from a seventeen-edge one. Reads issued during a conversion, conversion requests issued during busy, and requests issued in power-down each expose a design that takes a fresh word where the old one must remain.

// File: rtl/asp_pkg.sv
package asp_pkg;
  typedef enum logic [1:0] {
    XR_IDLE,
    XR_SYNC,
    XR_STREAM
  } xread_e;
endpackage

// File: rtl/asp_edge_decode.sv
module asp_edge_decode (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_conv,
  input  logic busy_n,
  input  logic pwr_down,
  input  logic ext_mode,
  output logic conv_go,
  output logic read_go
);
  logic cs_s, rc_s, cs_d, rc_d;
  logic cs_fall, rc_fall, rc_rise;
  logic conv_req, read_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_s <= 1'b1;
      rc_s <= 1'b1;
      cs_d <= 1'b1;
      rc_d <= 1'b1;
    end else begin
      cs_s <= cs_n;
      rc_s <= rd_conv;
      cs_d <= cs_s;
      rc_d <= rc_s;
    end
  end

  always_comb begin
    cs_fall  = cs_d & ~cs_s;
    rc_fall  = rc_d & ~rc_s;
    rc_rise  = ~rc_d & rc_s;
    conv_req = (~cs_s & rc_fall) | (~rc_s & cs_fall);
    read_req = (~cs_s & rc_rise) | (rc_s & cs_fall);
    conv_go  = conv_req & busy_n & ~pwr_down;
    read_go  = read_req & ext_mode;
  end
endmodule

// File: rtl/asp_conv_timer.sv
module asp_conv_timer #(
  parameter int WORD_W      = 16,
  parameter int CONV_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_go,
  input  logic [WORD_W-1:0] sample_in,
  input  logic              fmt_straight,
  output logic              busy_n,
  output logic [WORD_W-1:0] result
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] held;
  logic [WORD_W-1:0] coded;

  always_comb begin
    coded = sample_in;
    if (fmt_straight) coded[WORD_W-1] = ~sample_in[WORD_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_n <= 1'b1;
      cnt    <= '0;
      held   <= '0;
      result <= '0;
    end else if (busy_n) begin
      if (conv_go) begin
        busy_n <= 1'b0;
        cnt    <= CNT_START;
        held   <= coded;
      end
    end else if (cnt == '0) begin
      busy_n <= 1'b1;
      result <= held;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/asp_dclk_sync.sv
module asp_dclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_dclk,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], ext_dclk};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/asp_shifter.sv
module asp_shifter
  import asp_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int CLK_HALF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_mode,
  input  logic              int_load,
  input  logic              ext_load,
  input  logic              ext_rise,
  input  logic              tag_in,
  input  logic [WORD_W-1:0] word,
  output logic              dout,
  output logic              dclk_o,
  output logic              sync_o
);
  localparam int IC_W = (2 * CLK_HALF > 1) ? $clog2(2 * CLK_HALF) : 1;
  localparam int NS_W = $clog2(WORD_W + 1);
  localparam logic [IC_W-1:0] IC_MID  = IC_W'(CLK_HALF - 1);
  localparam logic [IC_W-1:0] IC_END  = IC_W'(2 * CLK_HALF - 1);
  localparam logic [NS_W-1:0] NS_LAST = NS_W'(WORD_W);

  logic [WORD_W-1:0] sh;
  logic [IC_W-1:0]   icnt;
  logic [NS_W-1:0]   nshift;
  logic              int_run;
  logic              tag_hold;
  xread_e            xst;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      icnt     <= '0;
      nshift   <= '0;
      int_run  <= 1'b0;
      tag_hold <= 1'b0;
      xst      <= XR_IDLE;
      dout     <= 1'b0;
      dclk_o   <= 1'b0;
      sync_o   <= 1'b0;
    end else if (int_load) begin
      dout     <= word[WORD_W-1];
      sh       <= {word[WORD_W-2:0], tag_in};
      tag_hold <= tag_in;
      nshift   <= NS_W'(1);
      icnt     <= '0;
      dclk_o   <= 1'b0;
      int_run  <= 1'b1;
      xst      <= XR_IDLE;
      sync_o   <= 1'b0;
    end else if (ext_load) begin
      sh      <= word;
      xst     <= XR_SYNC;
      int_run <= 1'b0;
      dclk_o  <= 1'b0;
      sync_o  <= 1'b0;
    end else begin
      if (int_run) begin
        if (icnt == IC_MID) dclk_o <= 1'b1;
        if (icnt == IC_END) begin
          icnt   <= '0;
          dclk_o <= 1'b0;
          dout   <= sh[WORD_W-1];
          if (nshift == NS_LAST) begin
            int_run <= 1'b0;
          end else begin
            sh     <= {sh[WORD_W-2:0], tag_hold};
            nshift <= nshift + 1'b1;
          end
        end else begin
          icnt <= icnt + 1'b1;
        end
      end
      if (ext_rise && ext_mode) begin
        case (xst)
          XR_SYNC: begin
            sync_o <= 1'b1;
            xst    <= XR_STREAM;
          end
          XR_STREAM: begin
            sync_o <= 1'b0;
            dout   <= sh[WORD_W-1];
            sh     <= {sh[WORD_W-2:0], tag_in};
          end
          default: sync_o <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int WORD_W      = 16,
  parameter int CONV_CYCLES = 40,
  parameter int CLK_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_conv,
  input  logic              ext_mode,
  input  logic              fmt_straight,
  input  logic              pwr_down,
  input  logic              tag_in,
  input  logic [WORD_W-1:0] sample_in,
  input  logic              ext_dclk,
  output logic              busy_n,
  output logic              dout,
  output logic              dclk_o,
  output logic              sync_o
);
  logic              conv_go;
  logic              read_go;
  logic              ext_rise;
  logic              int_load;
  logic [WORD_W-1:0] result;

  asp_edge_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .rd_conv  (rd_conv),
    .busy_n   (busy_n),
    .pwr_down (pwr_down),
    .ext_mode (ext_mode),
    .conv_go  (conv_go),
    .read_go  (read_go)
  );

  asp_conv_timer #(
    .WORD_W      (WORD_W),
    .CONV_CYCLES (CONV_CYCLES)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .conv_go      (conv_go),
    .sample_in    (sample_in),
    .fmt_straight (fmt_straight),
    .busy_n       (busy_n),
    .result       (result)
  );

  asp_dclk_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .ext_dclk (ext_dclk),
    .rise     (ext_rise)
  );

  assign int_load = conv_go & ~ext_mode;

  asp_shifter #(
    .WORD_W   (WORD_W),
    .CLK_HALF (CLK_HALF)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .ext_mode (ext_mode),
    .int_load (int_load),
    .ext_load (read_go),
    .ext_rise (ext_rise),
    .tag_in   (tag_in),
    .word     (result),
    .dout     (dout),
    .dclk_o   (dclk_o),
    .sync_o   (sync_o)
  );
endmodule

// File: rtl/asp_checker.sv
module asp_checker #(
  parameter int CONV_CYCLES = 40
) (
  input logic clk,
  input logic rst,
  input logic busy_n,
  input logic pwr_down,
  input logic ext_mode,
  input logic dout,
  input logic dclk_o,
  input logic sync_o
);
  localparam int LC_W = $clog2(CONV_CYCLES + 2) + 1;
  logic [LC_W-1:0] low_len;

  always_ff @(posedge clk) begin
    if (rst)          low_len <= '0;
    else if (!busy_n) low_len <= low_len + 1'b1;
    else              low_len <= '0;
  end

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_n) |-> (low_len == LC_W'(CONV_CYCLES)));

  // R4
  pwr_block_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n) |-> $past(!pwr_down));

  // R7
  bit_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!ext_mode && dclk_o && $past(dclk_o)) |-> $stable(dout));

  // R10
  sync_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> ext_mode);

  // R9
  burst_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dclk_o) |-> !ext_mode);
endmodule

bind adc_serial_port asp_checker #(
  .CONV_CYCLES (CONV_CYCLES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy_n   (busy_n),
  .pwr_down (pwr_down),
  .ext_mode (ext_mode),
  .dout     (dout),
  .dclk_o   (dclk_o),
  .sync_o   (sync_o)
);

// File: tb/adc_serial_port_tb.sv
`timescale 1ns/1ps
module adc_serial_port_tb;
  localparam int W    = 16;
  localparam int CONV = 40;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_conv = 1'b1, ext_mode = 1'b0, fmt_straight = 1'b0;
  logic pwr_down = 1'b0, tag_in = 1'b0, ext_dclk = 1'b0;
  logic [W-1:0] sample_in = '0;
  logic busy_n, dout, dclk_o, sync_o;

  always #2 clk = ~clk;

  adc_serial_port #(.WORD_W(W), .CONV_CYCLES(CONV), .CLK_HALF(HALF), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_conv(rd_conv), .ext_mode(ext_mode),
    .fmt_straight(fmt_straight), .pwr_down(pwr_down), .tag_in(tag_in),
    .sample_in(sample_in), .ext_dclk(ext_dclk), .busy_n(busy_n), .dout(dout),
    .dclk_o(dclk_o), .sync_o(sync_o)
  );

  int nchk = 0, nfail = 0;
  int bcnt = 0, last_len = 0, nconv = 0, npulse = 0, nunstable = 0;
  logic [W-1:0] word = '0;
  logic dprev = 1'b0, dlast = 1'b0;
  logic [W-1:0] exp_prev = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!busy_n) bcnt++;
      else if (bcnt != 0) begin
        last_len = bcnt;
        nconv++;
        bcnt = 0;
      end
      if (dclk_o && !dprev) begin
        word = {word[W-2:0], dout};
        npulse++;
      end
      if (dclk_o && dprev && (dout !== dlast)) nunstable++;
      dprev = dclk_o;
      dlast = dout;
    end
  end

  function automatic logic [W-1:0] fmt_code(logic [W-1:0] s, logic straight);
    return straight ? {~s[W-1], s[W-2:0]} : s;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // conversion by either control ordering (R1)
  task automatic do_conv(int style);
    if (style == 0) begin
      cs_n = 1'b0; tick(1); rd_conv = 1'b0; tick(1);
      cs_n = 1'b1; tick(1); rd_conv = 1'b1; tick(1);
    end else begin
      rd_conv = 1'b0; tick(1); cs_n = 1'b0; tick(1);
      cs_n = 1'b1; tick(1); rd_conv = 1'b1; tick(1);
    end
  endtask

  task automatic ext_pulse();
    ext_dclk = 1'b1; tick(HALF);
    ext_dclk = 1'b0; tick(HALF);
  endtask

  task automatic frame(logic [W-1:0] exp, string req);
    logic [W-1:0] got = '0, tgot = '0, tp;
    tp = W'($urandom);
    ext_pulse();
    chk("R10 sync high", 32'(sync_o), 32'd1);
    for (int k = 0; k < W; k++) begin
      tag_in = tp[W-1-k];
      ext_pulse();
      got = {got[W-2:0], dout};
      if (k == 0) chk("R10 sync low", 32'(sync_o), 32'd0);
    end
    tag_in = 1'b0;
    for (int k = 0; k < W; k++) begin
      ext_pulse();
      tgot = {tgot[W-2:0], dout};
    end
    chk(req, 32'(got), 32'(exp));
    chk("R11 tag delay", 32'(tgot), 32'(tp));
  endtask

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int c0;
    logic dsave;
    logic [W-1:0] a_smp;
    void'($urandom(32'd977));
    tick(5); rst = 1'b0; tick(3);
    chk("R1 reset busy", 32'(busy_n), 32'd1);
    chk("R8 reset dout", 32'(dout), 32'd0);
    chk("R10 reset sync", 32'(sync_o), 32'd0);
    chk("R6 reset dclk", 32'(dclk_o), 32'd0);

    // internal mode: directed extremes, then random words
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] smp;
      logic f, t;
      case (i)
        0: smp = 16'h8000;
        1: smp = 16'h7FFF;
        2: smp = 16'h0000;
        3: smp = 16'hFFFF;
        default: smp = W'($urandom);
      endcase
      f = (i < 4) ? i[0] : 1'($urandom);
      t = 1'($urandom);
      sample_in = smp; fmt_straight = f; tag_in = t;
      npulse = 0; c0 = nconv;
      do_conv(i % 2);
      tag_in = ~t;
      tick(160);
      chk("R2 busy length", 32'(last_len), 32'(CONV));
      chk("R1 conversion accepted", 32'(nconv), 32'(c0 + 1));
      chk("R6 pulse count", 32'(npulse), 32'd16);
      chk("R6 burst word", 32'(word), 32'(exp_prev));
      chk("R8 tag hold", 32'(dout), 32'(t));
      chk("R6 sync quiet", 32'(sync_o), 32'd0);
      exp_prev = fmt_code(smp, f);
    end
    chk("R7 bit stable", 32'(nunstable), 32'd0);

    // R5 directed: straight binary of 0x8000 must be 0x0000 on the next burst
    sample_in = 16'h8000; fmt_straight = 1'b1; npulse = 0;
    do_conv(1); tick(160);
    sample_in = 16'h1234; fmt_straight = 1'b0; npulse = 0;
    do_conv(0); tick(160);
    chk("R5 straight code", 32'(word), 32'h0000);
    exp_prev = 16'h1234;

    // R3: request during busy is ignored
    a_smp = 16'hA5C3;
    sample_in = a_smp; fmt_straight = 1'b0; c0 = nconv;
    rd_conv = 1'b0; tick(1); cs_n = 1'b0; tick(1); cs_n = 1'b1; tick(3);
    sample_in = 16'h3C5A;
    cs_n = 1'b0; tick(1); cs_n = 1'b1; tick(1); rd_conv = 1'b1; tick(1);
    tick(160);
    chk("R3 single conversion", 32'(nconv), 32'(c0 + 1));
    chk("R3 busy length", 32'(last_len), 32'(CONV));
    exp_prev = a_smp;

    // R4: power-down blocks conversions
    pwr_down = 1'b1; sample_in = 16'h0F0F; npulse = 0; c0 = nconv; dsave = dout;
    do_conv(1); tick(160);
    chk("R4 no conversion", 32'(nconv), 32'(c0));
    chk("R4 no burst", 32'(npulse), 32'd0);
    chk("R4 busy high", 32'(busy_n), 32'd1);
    chk("R4 dout kept", 32'(dout), 32'(dsave));
    pwr_down = 1'b0;

    // R9: read edges in internal mode do nothing
    npulse = 0; dsave = dout;
    cs_n = 1'b0; tick(1); cs_n = 1'b1; tick(60);
    chk("R9 no burst on read", 32'(npulse), 32'd0);
    chk("R9 dout unchanged", 32'(dout), 32'(dsave));
    chk("R9 no sync", 32'(sync_o), 32'd0);

    // external mode
    ext_mode = 1'b1; tick(2); npulse = 0;
    cs_n = 1'b0; tick(1); cs_n = 1'b1; tick(2);
    frame(exp_prev, "R4 result retained");

    for (int j = 0; j < 8; j++) begin
      logic [W-1:0] smp;
      logic f;
      smp = W'($urandom); f = 1'($urandom);
      sample_in = smp; fmt_straight = f;
      rd_conv = 1'b0; tick(1); cs_n = 1'b0; tick(1);
      tick(CONV + 10);
      rd_conv = 1'b1; tick(1); cs_n = 1'b1; tick(1);
      exp_prev = fmt_code(smp, f);
      frame(exp_prev, "R5 ext word");
      if (j % 2 == 1) begin
        cs_n = 1'b0; tick(1); cs_n = 1'b1; tick(2);
        frame(exp_prev, "R10 reread");
      end
    end

    // R12: read while converting returns previous word
    sample_in = 16'h6E21; fmt_straight = 1'b0;
    rd_conv = 1'b0; tick(1); cs_n = 1'b0; tick(1);
    rd_conv = 1'b1; tick(1); cs_n = 1'b1; tick(1);
    chk("R12 still busy", 32'(busy_n), 32'd0);
    frame(exp_prev, "R12 previous word");
    exp_prev = 16'h6E21;
    cs_n = 1'b0; tick(1); cs_n = 1'b1; tick(2);
    frame(exp_prev, "R12 new word");
    chk("R9 no dclk in ext mode", 32'(npulse), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule